// File: doc/BRIEF.md
# MDIO Management Controller

This block runs clause-22 management frames from a chip to external PHY devices. Software reaches it through a small word-indexed register port. That port holds a configuration word, a command word, a target address, outgoing write data, captured read data and an indicator word. The block derives the management clock from the system clock with one of eight divide ratios. It drives the shared data line through separate value, enable and input pins, so the pad cell stays outside the block.

A write frame starts as soon as software stores the write-data register. A read frame starts when software sets the command read bit where it was clear before. A scan mode repeats read frames for as long as its command bit stays set. Each scan read can step the register number. A not-valid indicator tells software whether the read-data register holds the result of the last read that was launched. A configuration bit removes the 32-bit preamble for PHYs that accept short frames.

Register indices on the port: 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 indicators.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset every register reads zero and the data line enable is low.
- R2: Configuration bits 2:0 select the MDC period in system clocks. Codes 0 to 7 give 4, 4, 6, 8, 10, 14, 20 and 28. MDC runs continuously.
- R3: A store to the write-data register sends a frame of 32 ones, then 01, then opcode 01, then the PHY address, the register number, the turnaround bits 10 and the 16 data bits. Fields go out MSB first. Each bit changes only on a falling MDC edge.
- R4: A read frame starts only when command bit 0 changes from 0 to 1. It uses opcode 10, and the block releases the line (enable low) for the two turnaround bits and the 16 data bits.
- R5: Read data is sampled on rising MDC edges and is reported in bits 15:0 of the read-data register.
- R6: Indicator bit 0 (busy) reads 1 from the cycle after a launch until the frame ends. Indicator bit 2 (not valid) sets when a read launches and clears when its data is captured.
- R7: With configuration bit 4 set, no preamble is sent and the frame begins with the start bits.
- R8: A launch request (read edge or write-data store) that arrives while busy is dropped and never produces a frame.
- R9: While command bit 1 is set, read frames repeat back to back and indicator bit 1 reads 1. With configuration bit 5 set, the register number steps by one after each scan read and wraps from 31 to 0.
- R10: Writing command bit 0 as 1 when it already holds 1 starts no frame.
- R11: Writing configuration bit 31 aborts any frame, releases the line and returns all registers to zero. The bit reads back as 0.
- R12: The address register holds the PHY address in bits 12:8 and the register number in bits 4:0. The frame carries these fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register index |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the index |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe_o | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
A write to the port takes effect on the next clock edge. Busy and not-valid are therefore read back at the negative clock edge that follows the write. The bench model decodes every frame on rising MDC. It presents read data on falling MDC, the same edge on which the controller changes its own bits, so each bit is stable for half an MDC period before the controller samples it. The end of a frame falls one falling MDC edge after the last data bit. Checks on frame results therefore wait for busy to clear, and never wait a fixed delay. Divider periods are measured between rising MDC edges after two settling periods.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS;
  localparam int DATA_BITS  = 16;
  localparam int FIELD_W    = 5;
  localparam int DIV_W      = 3;

  localparam int RIX_CFG   = 0;
  localparam int RIX_CMD   = 1;
  localparam int RIX_ADDR  = 2;
  localparam int RIX_WDATA = 3;
  localparam int RIX_RDATA = 4;
  localparam int RIX_IND   = 5;

  // half MDC period in system clocks for a divider code
  function automatic int unsigned half_period(input logic [DIV_W-1:0] sel);
    case (sel)
      3'd0, 3'd1: half_period = 2;
      3'd2:       half_period = 3;
      3'd3:       half_period = 4;
      3'd4:       half_period = 5;
      3'd5:       half_period = 7;
      3'd6:       half_period = 10;
      default:    half_period = 14;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
#(
  parameter int SEL_W   = DIV_W,
  parameter int MAX_HALF = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             mdc_o,
  output logic             rise_tick_o,
  output logic             fall_tick_o
);
  localparam int CNT_W = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign lim         = CNT_W'(half_period(sel_i) - 1);
  assign wrap        = (cnt_q >= lim) && !srst_i;
  assign rise_tick_o = wrap && !mdc_o;
  assign fall_tick_o = wrap && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (srst_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_rise_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_tick_o |=> mdc_o);
  assert_fall_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_tick_o |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int F_PRE  = PRE_BITS,
  parameter int F_HDR  = HDR_BITS,
  parameter int F_DATA = DATA_BITS,
  parameter int F_FLD  = FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              rise_tick_i,
  input  logic              fall_tick_i,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic              no_pre_i,
  input  logic [F_FLD-1:0]  phy_i,
  input  logic [F_FLD-1:0]  regno_i,
  input  logic [F_DATA-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [F_DATA-1:0] cap_o
);
  localparam int F_ALL   = F_PRE + F_HDR;
  localparam int TAIL_RD = F_DATA + 2;
  localparam int LEFT_W  = $clog2(F_ALL + 1);

  typedef enum logic [1:0] {ENG_IDLE, ENG_ARM, ENG_SHIFT} eng_state_e;

  eng_state_e        state_q;
  logic [F_ALL-1:0]  shreg_q;
  logic [LEFT_W-1:0] left_q;
  logic [LEFT_W-1:0] left_nx;
  logic              is_rd_q;
  logic [F_HDR-1:0]  hdr;

  // read: turnaround placeholder and data are released, value irrelevant
  assign hdr = start_rd_i ? {2'b01, 2'b10, phy_i, regno_i, 2'b11, {F_DATA{1'b0}}}
                          : {2'b01, 2'b01, phy_i, regno_i, 2'b10, wdata_i};
  assign left_nx = left_q - LEFT_W'(1);
  assign busy_o  = (state_q != ENG_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ENG_IDLE;
      shreg_q   <= '0;
      left_q    <= '0;
      is_rd_q   <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
      done_o    <= 1'b0;
      cap_o     <= '0;
    end else if (srst_i) begin
      state_q   <= ENG_IDLE;
      left_q    <= '0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
      done_o    <= 1'b0;
      cap_o     <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ENG_IDLE: if (start_i) begin
          is_rd_q <= start_rd_i;
          shreg_q <= no_pre_i ? {hdr, {F_PRE{1'b0}}} : {{F_PRE{1'b1}}, hdr};
          left_q  <= no_pre_i ? LEFT_W'(F_HDR) : LEFT_W'(F_ALL);
          state_q <= ENG_ARM;
        end
        default: begin
          if (rise_tick_i && state_q == ENG_SHIFT && is_rd_q && left_q < LEFT_W'(F_DATA))
            cap_o <= {cap_o[F_DATA-2:0], mdio_i};
          if (fall_tick_i) begin
            if (state_q == ENG_SHIFT && left_q == '0) begin
              mdio_oe_o <= 1'b0;
              done_o    <= 1'b1;
              state_q   <= ENG_IDLE;
            end else begin
              mdio_o    <= shreg_q[F_ALL-1];
              shreg_q   <= {shreg_q[F_ALL-2:0], 1'b0};
              left_q    <= left_nx;
              mdio_oe_o <= !is_rd_q || (left_nx >= LEFT_W'(TAIL_RD));
              state_q   <= ENG_SHIFT;
            end
          end
        end
      endcase
    end
  end

  assert_no_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ENG_IDLE));
  assert_bit_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_tick_i && !srst_i) |=> $stable(mdio_o));
  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_SHIFT && is_rd_q && left_q < LEFT_W'(TAIL_RD)) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 32,
  parameter int R_DATA = DATA_BITS,
  parameter int R_FLD  = FIELD_W,
  parameter int R_DIV  = DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic [R_DATA-1:0] eng_cap_i,
  output logic              start_o,
  output logic              start_rd_o,
  output logic [R_FLD-1:0]  phy_o,
  output logic [R_FLD-1:0]  regno_o,
  output logic [R_DATA-1:0] wdata_o,
  output logic              no_pre_o,
  output logic [R_DIV-1:0]  div_sel_o,
  output logic              srst_o
);
  logic [R_DIV-1:0]  div_q;
  logic              nopre_q, incr_q;
  logic [1:0]        cmd_q;
  logic [R_FLD-1:0]  phy_q, regno_q;
  logic [R_DATA-1:0] wd_q, rd_q;
  logic              nv_q, rd_infl_q, scan_infl_q;
  logic              wr_cfg, wr_cmd, wr_addr, wr_wd;
  logic              rd_edge, go_wr, go_rd, go_scan;

  assign wr_cfg  = bus_we_i && bus_addr_i == ADDR_W'(RIX_CFG);
  assign wr_cmd  = bus_we_i && bus_addr_i == ADDR_W'(RIX_CMD);
  assign wr_addr = bus_we_i && bus_addr_i == ADDR_W'(RIX_ADDR);
  assign wr_wd   = bus_we_i && bus_addr_i == ADDR_W'(RIX_WDATA);
  assign srst_o  = wr_cfg && bus_wdata_i[31];

  assign rd_edge = wr_cmd && bus_wdata_i[0] && !cmd_q[0];
  assign go_wr   = wr_wd && !eng_busy_i;
  assign go_rd   = rd_edge && !eng_busy_i;
  // hold scan off in the done cycle so the stepped register number is used
  assign go_scan = cmd_q[1] && !eng_busy_i && !eng_done_i && !go_wr && !go_rd && !srst_o;

  assign start_o    = go_wr || go_rd || go_scan;
  assign start_rd_o = go_rd || go_scan;
  assign phy_o      = phy_q;
  assign regno_o    = regno_q;
  assign wdata_o    = wr_wd ? bus_wdata_i[R_DATA-1:0] : wd_q;
  assign no_pre_o   = nopre_q;
  assign div_sel_o  = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; nopre_q <= 1'b0; incr_q <= 1'b0; cmd_q <= '0;
      phy_q <= '0; regno_q <= '0; wd_q <= '0; rd_q <= '0;
      nv_q <= 1'b0; rd_infl_q <= 1'b0; scan_infl_q <= 1'b0;
    end else if (srst_o) begin
      div_q <= '0; nopre_q <= 1'b0; incr_q <= 1'b0; cmd_q <= '0;
      phy_q <= '0; regno_q <= '0; wd_q <= '0; rd_q <= '0;
      nv_q <= 1'b0; rd_infl_q <= 1'b0; scan_infl_q <= 1'b0;
    end else begin
      if (eng_done_i) begin
        rd_infl_q   <= 1'b0;
        scan_infl_q <= 1'b0;
        if (rd_infl_q) begin
          rd_q <= eng_cap_i;
          nv_q <= 1'b0;
        end
        if (scan_infl_q && incr_q) regno_q <= regno_q + R_FLD'(1);
      end
      if (start_rd_o) begin
        rd_infl_q   <= 1'b1;
        scan_infl_q <= go_scan;
        nv_q        <= 1'b1;
      end
      if (wr_cfg) begin
        div_q   <= bus_wdata_i[R_DIV-1:0];
        nopre_q <= bus_wdata_i[4];
        incr_q  <= bus_wdata_i[5];
      end
      if (wr_cmd) cmd_q <= bus_wdata_i[1:0];
      if (wr_addr) begin
        phy_q   <= bus_wdata_i[8 +: R_FLD];
        regno_q <= bus_wdata_i[0 +: R_FLD];
      end
      if (wr_wd) wd_q <= bus_wdata_i[R_DATA-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (int'(bus_addr_i))
      RIX_CFG:   begin
        bus_rdata_o[R_DIV-1:0] = div_q;
        bus_rdata_o[4] = nopre_q;
        bus_rdata_o[5] = incr_q;
      end
      RIX_CMD:   bus_rdata_o[1:0] = cmd_q;
      RIX_ADDR:  begin
        bus_rdata_o[8 +: R_FLD] = phy_q;
        bus_rdata_o[0 +: R_FLD] = regno_q;
      end
      RIX_WDATA: bus_rdata_o[R_DATA-1:0] = wd_q;
      RIX_RDATA: bus_rdata_o[R_DATA-1:0] = rd_q;
      RIX_IND:   bus_rdata_o[2:0] = {nv_q, cmd_q[1], eng_busy_i};
      default:   bus_rdata_o = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata_i[BUS_W-2:16], bus_wdata_i[3]};

  assert_launch_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !srst_o) |=> eng_busy_i);
  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && rd_infl_q && !srst_o) |=> (rd_q == $past(eng_cap_i)) && !nv_q);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic                 srst, rise_tick, fall_tick;
  logic                 start, start_rd, no_pre, busy, done;
  logic [DIV_W-1:0]     div_sel;
  logic [FIELD_W-1:0]   phy, regno;
  logic [DATA_BITS-1:0] wdata, cap;

  mdio_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .eng_busy_i(busy), .eng_done_i(done), .eng_cap_i(cap),
    .start_o(start), .start_rd_o(start_rd), .phy_o(phy), .regno_o(regno),
    .wdata_o(wdata), .no_pre_o(no_pre), .div_sel_o(div_sel), .srst_o(srst)
  );

  mdio_clk_gen u_clk (
    .clk_i, .rst_ni, .srst_i(srst), .sel_i(div_sel),
    .mdc_o, .rise_tick_o(rise_tick), .fall_tick_o(fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk_i, .rst_ni, .srst_i(srst), .rise_tick_i(rise_tick), .fall_tick_i(fall_tick),
    .start_i(start), .start_rd_i(start_rd), .no_pre_i(no_pre),
    .phy_i(phy), .regno_i(regno), .wdata_i(wdata), .mdio_i,
    .mdio_o, .mdio_oe_o, .busy_o(busy), .done_o(done), .cap_o(cap)
  );

  assert_idle_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !mdio_oe_o && !busy);
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, mdoe;
  logic        mdi = 1'b1;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(mdoe), .mdio_i(mdi)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // PHY model state
  int          m_st = 0, m_cnt = 0, m_pre = 0;
  logic [13:0] m_hdr;
  logic [17:0] m_td;
  int          frame_cnt = 0, last_pre = 0, rd_oe_err = 0;
  logic [1:0]  last_op, last_ta;
  logic [4:0]  last_phy, last_reg;
  logic [15:0] last_data;
  logic [4:0]  log_reg [16];

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h2D};
  endfunction

  task automatic mon_clear();
    m_st = 0; m_cnt = 0; m_pre = 0;
  endtask

  always @(posedge mdc) begin
    case (m_st)
      0: if (mdoe) begin
        if (mdo) m_pre++;
        else begin m_st = 1; m_cnt = 1; m_hdr = '0; end
      end
      1: begin
        m_hdr = {m_hdr[12:0], mdo};
        m_cnt++;
        if (m_cnt == 14) begin
          last_op = m_hdr[11:10]; last_phy = m_hdr[9:5]; last_reg = m_hdr[4:0];
          m_st = (m_hdr[11:10] == 2'b10) ? 3 : 2;
          m_cnt = 0;
        end
      end
      2: begin
        m_td = {m_td[16:0], mdo};
        m_cnt++;
        if (m_cnt == 18) begin
          last_ta = m_td[17:16]; last_data = m_td[15:0];
          log_reg[frame_cnt % 16] = last_reg;
          frame_cnt++; last_pre = m_pre; m_pre = 0; m_st = 0;
        end
      end
      default: begin
        if (mdoe) rd_oe_err++;
        m_cnt++;
        if (m_cnt == 18) begin
          last_data = phy_val(last_phy, last_reg);
          log_reg[frame_cnt % 16] = last_reg;
          frame_cnt++; last_pre = m_pre; m_pre = 0; m_st = 0;
        end
      end
    endcase
  end

  always @(negedge mdc) begin
    #1;
    if (m_st == 3) mdi = (m_cnt >= 2) ? phy_val(last_phy, last_reg)[17 - m_cnt] : (m_cnt == 0);
    else mdi = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 3'(idx); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input int idx, output logic [31:0] d);
    @(negedge clk); addr = 3'(idx); #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(5, v);
      if (!v[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      reg_rd(i, v);
      chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 enable low", {31'b0, mdoe}, 32'h0);
  endtask

  task automatic t_divider();
    int codes [4] = '{0, 1, 3, 7};
    int exp   [4] = '{4, 4, 8, 28};
    for (int k = 0; k < 4; k++) begin
      time t0;
      reg_wr(0, 32'(codes[k]));
      repeat (2) @(posedge mdc);
      @(posedge mdc); t0 = $time;
      @(posedge mdc);
      chk("R2 mdc period", 32'(($time - t0) / 8), 32'(exp[k]));
    end
    reg_wr(0, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    int base = frame_cnt;
    reg_wr(2, {19'b0, 5'd5, 3'b0, 5'h12});
    reg_rd(2, v);
    chk("R12 address fields", v, 32'h0000_0512);
    reg_wr(3, 32'h0000_BEEF);
    reg_rd(5, v);
    chk("R6 busy after write launch", v, 32'h1);
    wait_idle();
    chk("R3 one frame", 32'(frame_cnt - base), 32'd1);
    chk("R3 opcode", {30'b0, last_op}, 32'h1);
    chk("R3 preamble", 32'(last_pre), 32'd32);
    chk("R12 phy field", {27'b0, last_phy}, 32'd5);
    chk("R12 reg field", {27'b0, last_reg}, 32'h12);
    chk("R3 turnaround", {30'b0, last_ta}, 32'h2);
    chk("R3 data", {16'b0, last_data}, 32'h0000_BEEF);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int base = frame_cnt;
    reg_wr(2, {19'b0, 5'd9, 3'b0, 5'h11});
    reg_wr(1, 32'h0);
    reg_wr(1, 32'h1);
    reg_rd(5, v);
    chk("R6 busy and not-valid at read launch", v, 32'h5);
    wait_idle();
    chk("R4 one read frame", 32'(frame_cnt - base), 32'd1);
    chk("R4 read opcode", {30'b0, last_op}, 32'h2);
    chk("R4 line released", 32'(rd_oe_err), 32'd0);
    reg_rd(4, v);
    chk("R5 read data", v, {16'b0, phy_val(5'd9, 5'h11)});
    reg_rd(5, v);
    chk("R6 not-valid cleared", v, 32'h0);
  endtask

  task automatic t_no_edge();
    logic [31:0] v;
    int base = frame_cnt;
    reg_wr(1, 32'h1);
    repeat (40) @(negedge clk);
    reg_rd(5, v);
    chk("R10 no launch without edge", v, 32'h0);
    chk("R10 no frame", 32'(frame_cnt - base), 32'd0);
  endtask

  task automatic t_busy_drop();
    logic [31:0] v;
    int base;
    reg_wr(1, 32'h0);
    base = frame_cnt;
    reg_wr(3, 32'h0000_1234);
    reg_wr(1, 32'h1);
    reg_wr(3, 32'h0000_5678);
    wait_idle();
    repeat (60) @(negedge clk);
    chk("R8 single frame", 32'(frame_cnt - base), 32'd1);
    chk("R8 first data kept", {16'b0, last_data}, 32'h0000_1234);
    reg_rd(5, v);
    chk("R8 read edge dropped", v, 32'h0);
    reg_wr(1, 32'h0);
  endtask

  task automatic t_nopre();
    int base = frame_cnt;
    reg_wr(0, 32'h10);
    reg_wr(3, 32'h0000_A5A5);
    wait_idle();
    chk("R7 frame sent", 32'(frame_cnt - base), 32'd1);
    chk("R7 no preamble", 32'(last_pre), 32'd0);
    chk("R7 data", {16'b0, last_data}, 32'h0000_A5A5);
    reg_wr(0, 32'h0);
  endtask

  task automatic t_scan();
    logic [31:0] v;
    int base, n;
    reg_wr(0, 32'h20);
    reg_wr(2, {19'b0, 5'd3, 3'b0, 5'd30});
    base = frame_cnt;
    reg_wr(1, 32'h2);
    reg_rd(5, v);
    chk("R9 scan indicator", {31'b0, v[1]}, 32'h1);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (frame_cnt - base >= 3) break;
    end
    reg_wr(1, 32'h0);
    wait_idle();
    n = frame_cnt - base;
    chk("R9 first scan reg", {27'b0, log_reg[base % 16]}, 32'd30);
    chk("R9 second scan reg", {27'b0, log_reg[(base + 1) % 16]}, 32'd31);
    chk("R9 wrap to zero", {27'b0, log_reg[(base + 2) % 16]}, 32'd0);
    reg_rd(2, v);
    chk("R9 stepped address", v, {19'b0, 5'd3, 3'b0, 5'((30 + n) % 32)});
    reg_rd(4, v);
    chk("R9 last scan data", v, {16'b0, phy_val(5'd3, 5'((30 + n - 1) % 32))});
    reg_rd(5, v);
    chk("R9 scan stopped", v, 32'h0);
    reg_wr(0, 32'h0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    int base;
    reg_wr(0, 32'h2);
    reg_wr(2, {19'b0, 5'd7, 3'b0, 5'd4});
    reg_wr(3, 32'h0000_0F0F);
    repeat (40) @(negedge clk);
    reg_wr(0, 32'h8000_0000);
    chk("R11 line released", {31'b0, mdoe}, 32'h0);
    for (int i = 0; i < 6; i++) begin
      reg_rd(i, v);
      chk("R11 registers cleared", v, 32'h0);
    end
    mon_clear();
    base = frame_cnt;
    repeat (400) @(negedge clk);
    chk("R11 frame aborted", 32'(frame_cnt - base), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divider();
    t_write();
    t_read();
    t_no_edge();
    t_busy_drop();
    t_nopre();
    t_scan();
    t_soft_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule